// File: doc/BRIEF.md
# Outstanding-Transaction and Response-Latency Limiter

This block sits between a memory-mapped manager and the subordinate it talks to, and slows the traffic down so that a fast memory behaves like a slower one. It controls two things. The first is how many read and write transactions may be in flight at once: there is a separate cap for reads, a separate cap for writes, and a third cap on the two together. The second is how soon a response may return: a read response or a write response is not passed back until a set number of cycles has gone by.

Every accepted transaction gets a release time, taken from a free-running cycle counter plus the configured latency. The release time goes into a small per-direction queue. The response from the subordinate is passed upstream only once the counter has reached the release time at the head of that queue. If the subordinate answers later than that, its response goes straight through with no extra delay. All five limits come from static configuration inputs, which are normally driven from registers elsewhere in the chip.

Top module: `axi_lat_limiter`

## Requirements
- R1: While `cfg_rd_cap` is nonzero and the number of pending reads equals or exceeds it, `up_arready` and `dn_arvalid` are low. A value of 0 places no cap on reads.
- R2: While `cfg_wr_cap` is nonzero and the number of pending writes equals or exceeds it, `up_awready` and `dn_awvalid` are low. A value of 0 places no cap on writes.
- R3: While `cfg_all_cap` is nonzero, pending reads plus pending writes never go past it. If one slot is left and a read address and a write address are both offered in the same cycle, the read is accepted and the write waits. A value of 0 places no combined cap.
- R4: A read counts as pending from the cycle its address handshake completes upstream until the cycle its beat with `up_rlast` completes upstream. A write counts as pending from its address handshake until its response handshake. A freed slot can be used in the next cycle.
- R5: Suppose a read address handshake completes in cycle k. The first data beat of that read is presented upstream no earlier than cycle k + max(`cfg_rd_lat`, 1).
- R6: Suppose the write data beat with `up_wlast` completes its handshake in cycle k. The matching write response is presented upstream no earlier than cycle k + max(`cfg_wr_lat`, 1).
- R7: Once a response's release time has passed, a response the subordinate presents goes upstream in the same cycle, and its ready is passed back down in that same cycle.
- R8: Within each direction, release times are used in acceptance order. A response that waits behind an earlier one starts in the cycle after the earlier one completes, or at its own release time if that is later.
- R9: A read address is held while the read release queue holds `RD_DEPTH` entries. A write address is held while `WR_DEPTH` writes are pending. A last write beat is held while the write release queue is full. All three apply even when every cap is 0.
- R10: After reset, no responses are presented upstream, no addresses are presented downstream, nothing is pending, and with all caps at 0 both address ready outputs follow the downstream ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd_cap | input | 6 | Cap on pending reads, 0 = no cap |
| cfg_wr_cap | input | 6 | Cap on pending writes, 0 = no cap |
| cfg_all_cap | input | 6 | Cap on pending reads plus writes, 0 = no cap |
| cfg_rd_lat | input | 12 | Minimum read response latency in cycles |
| cfg_wr_lat | input | 12 | Minimum write response latency in cycles |
| up_arvalid | input | 1 | Read address valid from the manager |
| up_arready | output | 1 | Read address ready to the manager |
| up_araddr | input | ADDR_W | Read address |
| up_rvalid | output | 1 | Read data valid to the manager |
| up_rready | input | 1 | Read data ready from the manager |
| up_rdata | output | DATA_W | Read data |
| up_rlast | output | 1 | Last read beat |
| up_awvalid | input | 1 | Write address valid from the manager |
| up_awready | output | 1 | Write address ready to the manager |
| up_awaddr | input | ADDR_W | Write address |
| up_wvalid | input | 1 | Write data valid from the manager |
| up_wready | output | 1 | Write data ready to the manager |
| up_wdata | input | DATA_W | Write data |
| up_wlast | input | 1 | Last write beat |
| up_bvalid | output | 1 | Write response valid to the manager |
| up_bready | input | 1 | Write response ready from the manager |
| up_bresp | output | 2 | Write response code |
| dn_arvalid | output | 1 | Read address valid to the subordinate |
| dn_arready | input | 1 | Read address ready from the subordinate |
| dn_araddr | output | ADDR_W | Read address |
| dn_rvalid | input | 1 | Read data valid from the subordinate |
| dn_rready | output | 1 | Read data ready to the subordinate |
| dn_rdata | input | DATA_W | Read data |
| dn_rlast | input | 1 | Last read beat |
| dn_awvalid | output | 1 | Write address valid to the subordinate |
| dn_awready | input | 1 | Write address ready from the subordinate |
| dn_awaddr | output | ADDR_W | Write address |
| dn_wvalid | output | 1 | Write data valid to the subordinate |
| dn_wready | input | 1 | Write data ready from the subordinate |
| dn_wdata | output | DATA_W | Write data |
| dn_wlast | output | 1 | Last write beat |
| dn_bvalid | input | 1 | Write response valid from the subordinate |
| dn_bready | output | 1 | Write response ready to the subordinate |
| dn_bresp | input | 2 | Write response code |

## Verification
Two events can land in the same cycle: a read address and a write address both competing for the last free slot under the combined cap. The bench provokes this by setting the combined cap to three and raising both address valids on the same clock edge. It expects two reads and one write to be accepted, and that count is read from the upstream handshakes. A second collision comes from back-to-back reads, where one read's release time passes while an earlier read is still streaming its beats. Here the scoreboard's expected first-beat cycle is the later of the release time and the cycle after the previous last beat.

// File: rtl/axi_lat_pkg.sv
package axi_lat_pkg;

  localparam int CAP_W  = 6;
  localparam int LAT_W  = 12;
  localparam int TIME_W = 16;
  localparam int CNT_W  = 8;

  // A zero cap means no limit; otherwise used must stay strictly below it.
  function automatic logic fits_cap(input logic [CAP_W-1:0] cap,
                                    input logic [CNT_W-1:0] used);
    return (cap == '0) || (used < CNT_W'(cap));
  endfunction

  // Earliest cycle-counter value at which a response may pass.
  function automatic logic [TIME_W-1:0] release_stamp(input logic [TIME_W-1:0] now,
                                                      input logic [LAT_W-1:0]  lat);
    return now + TIME_W'(lat);
  endfunction

  // Wrap-safe comparison: due while now is at or past stamp (within half the range).
  function automatic logic stamp_reached(input logic [TIME_W-1:0] now,
                                         input logic [TIME_W-1:0] stamp);
    logic [TIME_W-1:0] diff;
    diff = now - stamp;
    return !diff[TIME_W-1];
  endfunction

endpackage

// File: rtl/lat_stamp_fifo.sv
module lat_stamp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [FW-1:0] fill;
  logic          do_push, do_pop;

  assign empty   = (fill == '0);
  assign full    = (fill == FW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + FW'(1);
        2'b01:   fill <= fill - FW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/lat_pend_ctr.sv
module lat_pend_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (inc && !dec) cnt <= cnt + W'(1);
    else if (dec && !inc) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/lat_resp_gate.sv
module lat_resp_gate
  import axi_lat_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic              stamp_push,
  input  logic [LAT_W-1:0]  lat,
  input  logic              dn_valid,
  output logic              dn_ready,
  output logic              up_valid,
  input  logic              up_ready,
  input  logic              up_last,
  output logic              due,
  output logic              empty,
  output logic              full,
  output logic              done
);
  logic [TIME_W-1:0] head_stamp;

  lat_stamp_fifo #(.W(TIME_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (stamp_push),
    .din   (release_stamp(now, lat)),
    .pop   (done),
    .head  (head_stamp),
    .empty (empty),
    .full  (full)
  );

  assign due      = !empty && stamp_reached(now, head_stamp);
  assign up_valid = dn_valid && due;
  assign dn_ready = up_ready && due;
  assign done     = up_valid && up_ready && up_last;
endmodule

// File: rtl/axi_lat_limiter.sv
module axi_lat_limiter
  import axi_lat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAP_W-1:0]  cfg_rd_cap,
  input  logic [CAP_W-1:0]  cfg_wr_cap,
  input  logic [CAP_W-1:0]  cfg_all_cap,
  input  logic [LAT_W-1:0]  cfg_rd_lat,
  input  logic [LAT_W-1:0]  cfg_wr_lat,
  input  logic              up_arvalid,
  output logic              up_arready,
  input  logic [ADDR_W-1:0] up_araddr,
  output logic              up_rvalid,
  input  logic              up_rready,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_rlast,
  input  logic              up_awvalid,
  output logic              up_awready,
  input  logic [ADDR_W-1:0] up_awaddr,
  input  logic              up_wvalid,
  output logic              up_wready,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic              up_wlast,
  output logic              up_bvalid,
  input  logic              up_bready,
  output logic [1:0]        up_bresp,
  output logic              dn_arvalid,
  input  logic              dn_arready,
  output logic [ADDR_W-1:0] dn_araddr,
  input  logic              dn_rvalid,
  output logic              dn_rready,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_rlast,
  output logic              dn_awvalid,
  input  logic              dn_awready,
  output logic [ADDR_W-1:0] dn_awaddr,
  output logic              dn_wvalid,
  input  logic              dn_wready,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_wlast,
  input  logic              dn_bvalid,
  output logic              dn_bready,
  input  logic [1:0]        dn_bresp
);
  localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(WR_DEPTH);

  // Named internal events, used by the bound checker.
  logic [TIME_W-1:0] now;
  logic [CNT_W-1:0]  rd_pend, wr_pend, all_pend;
  logic              ar_ok, aw_ok, w_ok;
  logic              ar_take, aw_take, wl_take;
  logic              r_done, b_done;
  logic              rd_due, wr_due;
  logic              rq_empty, rq_full, wq_empty, wq_full;
  logic              b_last_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + TIME_W'(1);
  end

  lat_pend_ctr #(.W(CNT_W)) u_rd_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ar_take), .dec(r_done), .cnt(rd_pend));
  lat_pend_ctr #(.W(CNT_W)) u_wr_ctr (
    .clk(clk), .rst_n(rst_n), .inc(aw_take), .dec(b_done), .cnt(wr_pend));

  assign all_pend = rd_pend + wr_pend;

  // Address admission; reads take precedence for the last combined slot.
  always_comb begin
    ar_ok   = fits_cap(cfg_rd_cap, rd_pend) && fits_cap(cfg_all_cap, all_pend) && !rq_full;
    ar_take = up_arvalid && dn_arready && ar_ok;
    aw_ok   = fits_cap(cfg_wr_cap, wr_pend)
           && fits_cap(cfg_all_cap, all_pend + CNT_W'(ar_take))
           && (wr_pend < WR_LIMIT);
    aw_take = up_awvalid && dn_awready && aw_ok;
  end

  assign dn_arvalid = up_arvalid && ar_ok;
  assign up_arready = dn_arready && ar_ok;
  assign dn_araddr  = up_araddr;
  assign dn_awvalid = up_awvalid && aw_ok;
  assign up_awready = dn_awready && aw_ok;
  assign dn_awaddr  = up_awaddr;

  // Write data passes through; only the last beat waits for a free stamp slot.
  assign w_ok      = !(up_wlast && wq_full);
  assign dn_wvalid = up_wvalid && w_ok;
  assign up_wready = dn_wready && w_ok;
  assign dn_wdata  = up_wdata;
  assign dn_wlast  = up_wlast;
  assign wl_take   = up_wvalid && up_wready && up_wlast;

  lat_resp_gate #(.DEPTH(RD_DEPTH)) u_rd_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .now        (now),
    .stamp_push (ar_take),
    .lat        (cfg_rd_lat),
    .dn_valid   (dn_rvalid),
    .dn_ready   (dn_rready),
    .up_valid   (up_rvalid),
    .up_ready   (up_rready),
    .up_last    (dn_rlast),
    .due        (rd_due),
    .empty      (rq_empty),
    .full       (rq_full),
    .done       (r_done)
  );

  assign b_last_unused = 1'b1;

  lat_resp_gate #(.DEPTH(WR_DEPTH)) u_wr_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .now        (now),
    .stamp_push (wl_take),
    .lat        (cfg_wr_lat),
    .dn_valid   (dn_bvalid),
    .dn_ready   (dn_bready),
    .up_valid   (up_bvalid),
    .up_ready   (up_bready),
    .up_last    (b_last_unused),
    .due        (wr_due),
    .empty      (wq_empty),
    .full       (wq_full),
    .done       (b_done)
  );

  assign up_rdata = dn_rdata;
  assign up_rlast = dn_rlast;
  assign up_bresp = dn_bresp;
endmodule

// File: rtl/axi_lat_limiter_chk.sv
module axi_lat_limiter_chk
  import axi_lat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CAP_W-1:0] cfg_rd_cap,
  input logic [CAP_W-1:0] cfg_wr_cap,
  input logic [CAP_W-1:0] cfg_all_cap,
  input logic             up_arready,
  input logic             up_awready,
  input logic             up_rvalid,
  input logic             up_rready,
  input logic             up_bvalid,
  input logic             up_bready,
  input logic             dn_rvalid,
  input logic             dn_rready,
  input logic             dn_bvalid,
  input logic             dn_bready,
  input logic [CNT_W-1:0] rd_pend,
  input logic [CNT_W-1:0] wr_pend,
  input logic             ar_take,
  input logic             aw_take,
  input logic             wl_take,
  input logic             r_done,
  input logic             b_done,
  input logic             rd_due,
  input logic             wr_due,
  input logic             rq_empty,
  input logic             wq_empty
);
  p_rd_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_cap != '0 && rd_pend >= CNT_W'(cfg_rd_cap)) |-> !up_arready);

  p_wr_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_cap != '0 && wr_pend >= CNT_W'(cfg_wr_cap)) |-> !up_awready);

  p_all_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_all_cap != '0 && (rd_pend + wr_pend) >= CNT_W'(cfg_all_cap))
      |-> (!up_arready && !up_awready));

  p_read_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_all_cap != '0 && (rd_pend + wr_pend + CNT_W'(1)) == CNT_W'(cfg_all_cap) && ar_take)
      |-> !aw_take);

  p_rd_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_take && !r_done) |=> (rd_pend == $past(rd_pend) + CNT_W'(1)));

  p_rd_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && !ar_take) |=> (rd_pend == $past(rd_pend) - CNT_W'(1)));

  p_wr_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_take && !b_done) |=> (wr_pend == $past(wr_pend) + CNT_W'(1)));

  p_no_early_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_empty && !ar_take) |=> !up_rvalid);

  p_no_early_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_empty && !wl_take) |=> !up_bvalid);

  p_r_straight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rvalid && rd_due && up_rready) |-> (up_rvalid && dn_rready));

  p_b_straight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_bvalid && wr_due && up_bready) |-> (up_bvalid && dn_bready));
endmodule

bind axi_lat_limiter axi_lat_limiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rd_cap  (cfg_rd_cap),
  .cfg_wr_cap  (cfg_wr_cap),
  .cfg_all_cap (cfg_all_cap),
  .up_arready  (up_arready),
  .up_awready  (up_awready),
  .up_rvalid   (up_rvalid),
  .up_rready   (up_rready),
  .up_bvalid   (up_bvalid),
  .up_bready   (up_bready),
  .dn_rvalid   (dn_rvalid),
  .dn_rready   (dn_rready),
  .dn_bvalid   (dn_bvalid),
  .dn_bready   (dn_bready),
  .rd_pend     (rd_pend),
  .wr_pend     (wr_pend),
  .ar_take     (ar_take),
  .aw_take     (aw_take),
  .wl_take     (wl_take),
  .r_done      (r_done),
  .b_done      (b_done),
  .rd_due      (rd_due),
  .wr_due      (wr_due),
  .rq_empty    (rq_empty),
  .wq_empty    (wq_empty)
);

// File: tb/sim_axi_lat_limiter.sv
`timescale 1ns/1ps
module sim_axi_lat_limiter;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int RB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0]  cfg_rd_cap = '0, cfg_wr_cap = '0, cfg_all_cap = '0;
  logic [11:0] cfg_rd_lat = '0, cfg_wr_lat = '0;
  logic          up_arvalid = 0, up_awvalid = 0, up_wvalid = 0, up_wlast = 0;
  logic          up_rready = 1, up_bready = 1;
  logic [AW-1:0] up_araddr = '0, up_awaddr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic          up_arready, up_rvalid, up_rlast, up_awready, up_wready, up_bvalid;
  logic [DW-1:0] up_rdata;
  logic [1:0]    up_bresp;
  logic          dn_arvalid, dn_rready, dn_awvalid, dn_wvalid, dn_wlast, dn_bready;
  logic [AW-1:0] dn_araddr, dn_awaddr;
  logic [DW-1:0] dn_wdata;
  logic          dn_arready = 1, dn_awready = 1, dn_wready = 1;
  logic          dn_rvalid = 0, dn_rlast = 0, dn_bvalid = 0;
  logic [DW-1:0] dn_rdata = '0;
  logic [1:0]    dn_bresp = '0;

  axi_lat_limiter u0 (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;
  int sub_rd_dly = 1, sub_wr_dly = 1;

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Subordinate model: fixed response delay, in-order, RB beats per read.
  initial begin
    int rdue[$];
    int bdue[$];
    int rbeat = 0;
    bit ar_hs, r_hs, wl_hs, b_hs;
    int k;
    forever begin
      @(negedge clk);
      k = cyc;
      ar_hs = dn_arvalid && dn_arready;
      r_hs  = dn_rvalid && dn_rready;
      wl_hs = dn_wvalid && dn_wready && dn_wlast;
      b_hs  = dn_bvalid && dn_bready;
      @(posedge clk); #1;
      if (ar_hs) rdue.push_back(k + sub_rd_dly);
      if (wl_hs) bdue.push_back(k + sub_wr_dly);
      if (r_hs) begin
        if (rbeat == RB - 1) begin rbeat = 0; void'(rdue.pop_front()); end
        else rbeat++;
      end
      if (b_hs) void'(bdue.pop_front());
      dn_rvalid = (rdue.size() > 0) && (cyc >= rdue[0]);
      dn_rlast  = (rbeat == RB - 1);
      dn_rdata  = DW'(cyc);
      dn_bvalid = (bdue.size() > 0) && (cyc >= bdue[0]);
    end
  end

  // Scoreboard monitor: expected release cycles pushed at request, popped at response.
  int exp_r[$], exp_b[$];
  int ar_cyc[$], aw_cyc[$], rl_cyc[$], b_cyc[$];
  int ar_total = 0, aw_total = 0, r_total = 0, b_total = 0, wl_total = 0;
  initial begin
    int up_beat = 0;
    int last_r = -100, last_b = -100;
    int e, base;
    string lbl;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (up_arvalid && up_arready) begin
          ar_total++; ar_cyc.push_back(cyc);
          exp_r.push_back(cyc + mx(mx(int'(cfg_rd_lat), sub_rd_dly), 1));
        end
        if (up_awvalid && up_awready) begin aw_total++; aw_cyc.push_back(cyc); end
        if (up_wvalid && up_wready && up_wlast) begin
          wl_total++;
          exp_b.push_back(cyc + mx(mx(int'(cfg_wr_lat), sub_wr_dly), 1));
        end
        if (up_rvalid && up_rready) begin
          if (up_beat == 0) begin
            if (exp_r.size() == 0) chk(1, 0, "R5 unexpected read data");
            else begin
              base = exp_r.pop_front();
              e = mx(base, last_r + 1);
              if (e > base) lbl = "R8 read order";
              else if (sub_rd_dly > int'(cfg_rd_lat)) lbl = "R7 read passthrough";
              else lbl = "R5 read latency";
              chk(cyc, e, lbl);
            end
          end
          if (up_rlast) begin
            up_beat = 0; last_r = cyc; r_total++; rl_cyc.push_back(cyc);
          end else up_beat++;
        end
        if (up_bvalid && up_bready) begin
          if (exp_b.size() == 0) chk(1, 0, "R6 unexpected write response");
          else begin
            base = exp_b.pop_front();
            e = mx(base, last_b + 1);
            if (e > base) lbl = "R8 write order";
            else if (sub_wr_dly > int'(cfg_wr_lat)) lbl = "R7 write passthrough";
            else lbl = "R6 write latency";
            chk(cyc, e, lbl);
          end
          b_total++; last_b = cyc; b_cyc.push_back(cyc);
        end
      end
    end
  end

  task automatic send_ar();
    bit got = 0;
    up_arvalid = 1; up_araddr = up_araddr + 32'h40;
    while (!got) begin @(negedge clk); got = up_arready; tick(); end
    up_arvalid = 0;
  endtask

  task automatic send_aw();
    bit got = 0;
    up_awvalid = 1; up_awaddr = up_awaddr + 32'h40;
    while (!got) begin @(negedge clk); got = up_awready; tick(); end
    up_awvalid = 0;
  endtask

  task automatic send_w();
    for (int b = 0; b < 2; b++) begin
      bit got = 0;
      up_wvalid = 1; up_wlast = (b == 1); up_wdata = DW'(b + 7);
      while (!got) begin @(negedge clk); got = up_wready; tick(); end
    end
    up_wvalid = 0; up_wlast = 0;
  endtask

  task automatic wait_idle();
    while (r_total < ar_total || b_total < aw_total || b_total < wl_total || up_rvalid || up_bvalid)
      tick();
    repeat (3) tick();
  endtask

  task automatic clear_logs();
    ar_cyc.delete(); aw_cyc.delete(); rl_cyc.delete(); b_cyc.delete();
  endtask

  task automatic lat_read(input int l, input int d);
    cfg_rd_lat = 12'(l); sub_rd_dly = d;
    send_ar(); wait_idle();
  endtask

  task automatic lat_write(input int l, input int d);
    cfg_wr_lat = 12'(l); sub_wr_dly = d;
    send_aw(); repeat (3) tick(); send_w(); wait_idle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    int base_ar, base_aw;
    repeat (5) tick();
    rst_n = 1;
    tick();

    // R10: reset state
    @(negedge clk);
    chk(int'(up_rvalid), 0, "R10 rvalid");
    chk(int'(up_bvalid), 0, "R10 bvalid");
    chk(int'(dn_arvalid), 0, "R10 dn_arvalid");
    chk(int'(up_arready), 1, "R10 arready");
    chk(int'(up_awready), 1, "R10 awready");
    tick();

    // R5 / R7 read latency, R6 / R7 write latency
    lat_read(10, 2);
    lat_read(3, 12);
    lat_read(0, 1);
    lat_read(1, 1);
    lat_write(8, 1);
    lat_write(2, 9);
    lat_write(0, 1);

    // R8: back-to-back reads whose release windows overlap
    cfg_rd_lat = 12'd20; sub_rd_dly = 1;
    repeat (3) send_ar();
    wait_idle();

    // R1 + R4: read cap of 3, slot reused the cycle after a last beat
    clear_logs();
    cfg_rd_cap = 6'd3; cfg_rd_lat = 12'd40; sub_rd_dly = 1;
    base_ar = ar_total;
    fork begin repeat (5) send_ar(); end join_none
    repeat (15) tick();
    chk(ar_total - base_ar, 3, "R1 read cap count");
    @(negedge clk); chk(int'(up_arready), 0, "R1 arready held");
    tick();
    while (ar_total < base_ar + 5) tick();
    chk(ar_cyc[3], rl_cyc[0] + 1, "R4 read slot freed");
    wait_idle();
    cfg_rd_cap = '0;

    // R2 + R4: write cap of 2
    clear_logs();
    cfg_wr_cap = 6'd2; cfg_wr_lat = 12'd5; sub_wr_dly = 1;
    base_aw = aw_total;
    fork
      begin repeat (4) send_aw(); end
      begin repeat (4) send_w(); end
    join_none
    repeat (4) tick();
    chk(aw_total - base_aw, 2, "R2 write cap count");
    @(negedge clk); chk(int'(up_awready), 0, "R2 awready held");
    tick();
    while (aw_total < base_aw + 4) tick();
    chk(aw_cyc[2], b_cyc[0] + 1, "R4 write slot freed");
    wait_idle();
    cfg_wr_cap = '0;

    // R3: combined cap of 3, read and write contend for the last slot
    clear_logs();
    cfg_all_cap = 6'd3; cfg_rd_lat = 12'd30; cfg_wr_lat = 12'd30;
    base_ar = ar_total; base_aw = aw_total;
    fork
      begin repeat (3) send_ar(); end
      begin repeat (3) send_aw(); end
      begin repeat (3) send_w(); end
    join_none
    repeat (10) tick();
    chk(ar_total - base_ar, 2, "R3 reads admitted");
    chk(aw_total - base_aw, 1, "R3 writes admitted");
    while (ar_total < base_ar + 3 || aw_total < base_aw + 3) tick();
    wait_idle();
    cfg_all_cap = '0;

    // R9: all caps zero, read queue depth bounds admission
    cfg_rd_lat = 12'd50; sub_rd_dly = 1;
    base_ar = ar_total;
    fork begin repeat (10) send_ar(); end join_none
    repeat (20) tick();
    chk(ar_total - base_ar, 8, "R9 read depth bound");
    @(negedge clk); chk(int'(up_arready), 0, "R9 arready held");
    tick();
    while (ar_total < base_ar + 10) tick();
    wait_idle();

    chk(exp_r.size(), 0, "R8 read queue drained");
    chk(exp_b.size(), 0, "R8 write queue drained");
    summary();
  end
endmodule